// File: doc/BRIEF.md
# Pin I/O Controller with Interrupt Detection

This block drives and senses up to 32 general-purpose pins under control of a 32-bit register bus with APB-style timing. Each pin can be handed to an alternate-function source, or run under register control with its own direction, output enable and output value. Pin inputs are brought into the clock domain through a two-flop synchronizer. They are then watched for a programmable interrupt condition: a high or low level, a rising or falling edge, or either edge.

Detected events collect in a status register that clears itself when it is read. No acknowledge register exists. Interrupt masking is changed only through two write-one-to-act registers, one that unmasks and one that masks. The single interrupt output is high while any status bit is set whose mask bit is clear.

The bus always completes an access in one access phase: `bus_ready` is tied high and never applies back-pressure. A write takes effect on the clock edge that ends the access phase. Read data is valid during the access phase.

Top module: `pinctl_gpio`

## Requirements
- R1: After reset the mask register reads all ones and the direction register reads all ones (input) over the implemented pins. Output enable, output value, status, type, polarity and both-edge registers read zero. The alternate-select register reads the `ALT_RST` parameter limited to the pin count.
- R2: Register word offsets are: alternate select 0x00, direction 0x04, output enable 0x08, output value 0x0C, input level 0x10, mask 0x14, unmask 0x18, mask-set 0x1C, status 0x20, type 0x24, polarity 0x28, both-edge 0x2C. Bits at or above `PIN_COUNT` read zero, and offsets from 0x30 upward read zero.
- R3: For a pin with alternate select 0, a direction bit of 1 makes it an input and forces `pin_oe` low. A direction bit of 0 sets `pin_oe` to the output-enable bit. `pin_out` always equals the output-value bit.
- R4: For a pin with alternate select 1, `pin_out` and `pin_oe` follow `alt_out` and `alt_oe`. `alt_in` always mirrors `pin_in`.
- R5: The output-value register reads back the last written value, not the pin level. The input-level register returns `pin_in` delayed by two clock edges.
- R6: Writing 1 to an unmask-register bit clears that mask bit, and writing 1 to a mask-set bit sets it. Zero bits leave the mask unchanged. Both registers read zero.
- R7: With type bit 1 the pin is level sensitive. A polarity bit of 1 sets status while the synchronized pin is high; 0 sets it while the pin is low. Status is re-set every cycle the level holds.
- R8: With type bit 0 and both-edge bit 0, a polarity bit of 1 sets status on a rising edge and 0 on a falling edge. The status bit appears on the third clock edge after the pin changes.
- R9: With type bit 0 and both-edge bit 1, both edges set status.
- R10: A status read returns the pending bits and clears them on the edge that ends the access. An event detected in that same cycle stays set.
- R11: `irq` is high exactly when some status bit is set whose mask bit is clear. Masked pins still record status.
- R12: `bus_ready` is always high. A setup phase without an access phase writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus select (setup and access phases) |
| bus_enable | input | 1 | Access phase qualifier |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits [5:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access phase |
| bus_ready | output | 1 | Always 1 |
| pin_in | input | PIN_COUNT | Pin input levels |
| pin_out | output | PIN_COUNT | Pin output levels |
| pin_oe | output | PIN_COUNT | Pin output enables |
| alt_out | input | PIN_COUNT | Alternate-function output levels |
| alt_oe | input | PIN_COUNT | Alternate-function output enables |
| alt_in | output | PIN_COUNT | Pin levels forwarded to the alternate function |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The pin muxing (`pin_out`, `pin_oe`, `alt_in`) is combinational, so the bench samples it one time step after the register write completes or the input moves. Register writes are visible to a read that starts at the next falling edge. The input-level register lags `pin_in` by two rising edges, and an edge or level event reaches status and `irq` on the third rising edge. The bench drives every stimulus on a falling edge and counts falling edges to sample exactly before and after each due edge. It starts a status read one cycle after an edge so that the read's clearing edge coincides with the capture edge of a new event.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
  localparam int unsigned BUS_AW = 6;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned SEL_W  = 4;

  typedef enum logic [SEL_W-1:0] {
    RG_ALT  = 4'h0,
    RG_DIR  = 4'h1,
    RG_OE   = 4'h2,
    RG_DOUT = 4'h3,
    RG_DIN  = 4'h4,
    RG_MASK = 4'h5,
    RG_UNMK = 4'h6,
    RG_SETM = 4'h7,
    RG_STAT = 4'h8,
    RG_TYPE = 4'h9,
    RG_POL  = 4'hA,
    RG_BOTH = 4'hB
  } reg_sel_e;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [SEL_W-1:0]  sel;
    logic [BUS_DW-1:0] wdata;
  } bus_req_t;
endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_sync,
  output logic [WIDTH-1:0] d_prev
);
  localparam int unsigned TOTAL = DEPTH + 1;

  logic [WIDTH-1:0] chain [TOTAL];

  generate
    for (genvar s = 0; s < TOTAL; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain[DEPTH-1];
  assign d_prev = chain[DEPTH];
endmodule

// File: rtl/pinctl_regbank.sv
module pinctl_regbank
  import pinctl_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 32,
  parameter logic [31:0] ALT_RST   = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_enable,
  input  logic                 bus_write,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [BUS_DW-1:0]    bus_wdata,
  output logic [BUS_DW-1:0]    bus_rdata,
  input  logic [PIN_COUNT-1:0] din_sync,
  input  logic [PIN_COUNT-1:0] status,
  output logic [PIN_COUNT-1:0] alt_sel,
  output logic [PIN_COUNT-1:0] dir,
  output logic [PIN_COUNT-1:0] oe,
  output logic [PIN_COUNT-1:0] dout,
  output logic [PIN_COUNT-1:0] itype,
  output logic [PIN_COUNT-1:0] ipol,
  output logic [PIN_COUNT-1:0] iboth,
  output logic [PIN_COUNT-1:0] mask,
  output logic                 stat_rd
);
  localparam int unsigned N = PIN_COUNT;

  bus_req_t       req;
  logic [N-1:0]   wbits;

  function automatic logic [BUS_DW-1:0] zx(input logic [N-1:0] v);
    logic [BUS_DW-1:0] r;
    r        = '0;
    r[N-1:0] = v;
    return r;
  endfunction

  always_comb begin
    req.wr    = bus_sel & bus_enable & bus_write;
    req.rd    = bus_sel & bus_enable & ~bus_write;
    req.sel   = bus_addr[BUS_AW-1:2];
    req.wdata = bus_wdata;
  end

  assign wbits   = req.wdata[N-1:0];
  assign stat_rd = req.rd && (req.sel == RG_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_sel <= ALT_RST[N-1:0];
      dir     <= '1;
      oe      <= '0;
      dout    <= '0;
      itype   <= '0;
      ipol    <= '0;
      iboth   <= '0;
    end else if (req.wr) begin
      case (req.sel)
        RG_ALT:  alt_sel <= wbits;
        RG_DIR:  dir     <= wbits;
        RG_OE:   oe      <= wbits;
        RG_DOUT: dout    <= wbits;
        RG_TYPE: itype   <= wbits;
        RG_POL:  ipol    <= wbits;
        RG_BOTH: iboth   <= wbits;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '1;
    end else if (req.wr && req.sel == RG_UNMK) begin
      mask <= mask & ~wbits;
    end else if (req.wr && req.sel == RG_SETM) begin
      mask <= mask | wbits;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (req.rd) begin
      case (req.sel)
        RG_ALT:  bus_rdata = zx(alt_sel);
        RG_DIR:  bus_rdata = zx(dir);
        RG_OE:   bus_rdata = zx(oe);
        RG_DOUT: bus_rdata = zx(dout);
        RG_DIN:  bus_rdata = zx(din_sync);
        RG_MASK: bus_rdata = zx(mask);
        RG_STAT: bus_rdata = zx(status);
        RG_TYPE: bus_rdata = zx(itype);
        RG_POL:  bus_rdata = zx(ipol);
        RG_BOTH: bus_rdata = zx(iboth);
        default: bus_rdata = '0;
      endcase
    end
  end

  // R6
  unmask_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req.wr && req.sel == RG_UNMK) |=> ((mask & $past(wbits)) == '0));

  // R6
  setmask_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req.wr && req.sel == RG_SETM) |=> ((mask & $past(wbits)) == $past(wbits)));

  // R6
  zero_bits_keep_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req.wr && (req.sel == RG_UNMK || req.sel == RG_SETM)) |=>
      ((mask & ~$past(wbits)) == ($past(mask) & ~$past(wbits))));

  // R2
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req.rd && req.sel > RG_BOTH) |-> (bus_rdata == '0));
endmodule

// File: rtl/pinctl_irq.sv
module pinctl_irq #(
  parameter int unsigned PIN_COUNT = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIN_COUNT-1:0] lvl_now,
  input  logic [PIN_COUNT-1:0] lvl_prev,
  input  logic [PIN_COUNT-1:0] itype,
  input  logic [PIN_COUNT-1:0] ipol,
  input  logic [PIN_COUNT-1:0] iboth,
  input  logic [PIN_COUNT-1:0] mask,
  input  logic                 stat_rd,
  output logic [PIN_COUNT-1:0] status,
  output logic                 irq
);
  localparam int unsigned N = PIN_COUNT;

  logic [N-1:0] hit;
  logic [N-1:0] lvl_hit;
  logic [N-1:0] edge_hit;

  generate
    for (genvar p = 0; p < N; p++) begin : g_pin
      logic rise, fall, one_edge;
      assign rise        = lvl_now[p] & ~lvl_prev[p];
      assign fall        = ~lvl_now[p] & lvl_prev[p];
      assign one_edge    = ipol[p] ? rise : fall;
      assign lvl_hit[p]  = itype[p] & (lvl_now[p] == ipol[p]);
      assign edge_hit[p] = ~itype[p] & (iboth[p] ? (rise | fall) : one_edge);
    end
  endgenerate

  assign hit = lvl_hit | edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status <= '0;
    else if (stat_rd) status <= hit;
    else              status <= status | hit;
  end

  assign irq = |(status & ~mask);

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && hit == '0) |=> (status == '0));

  // R8
  edge_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((status & $past(edge_hit)) == $past(edge_hit)));

  // R7
  level_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_hit != '0) |=> ((status & $past(lvl_hit)) == $past(lvl_hit)));

  // R11
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !irq);
endmodule

// File: rtl/pinctl_gpio.sv
module pinctl_gpio
  import pinctl_pkg::*;
#(
  parameter int unsigned PIN_COUNT  = 32,
  parameter int unsigned SYNC_DEPTH = 2,
  parameter logic [31:0] ALT_RST    = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_enable,
  input  logic                 bus_write,
  input  logic [5:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_ready,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe,
  input  logic [PIN_COUNT-1:0] alt_out,
  input  logic [PIN_COUNT-1:0] alt_oe,
  output logic [PIN_COUNT-1:0] alt_in,
  output logic                 irq
);
  localparam int unsigned N = PIN_COUNT;

  logic [N-1:0] lvl_now, lvl_prev;
  logic [N-1:0] alt_sel, dir, oe, dout, itype, ipol, iboth, mask, status;
  logic         stat_rd;

  assign bus_ready = 1'b1;
  assign alt_in    = pin_in;

  pinctl_sync #(.WIDTH(N), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   (pin_in),
    .d_sync (lvl_now),
    .d_prev (lvl_prev)
  );

  pinctl_regbank #(.PIN_COUNT(N), .ALT_RST(ALT_RST)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_enable (bus_enable),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .din_sync   (lvl_now),
    .status     (status),
    .alt_sel    (alt_sel),
    .dir        (dir),
    .oe         (oe),
    .dout       (dout),
    .itype      (itype),
    .ipol       (ipol),
    .iboth      (iboth),
    .mask       (mask),
    .stat_rd    (stat_rd)
  );

  pinctl_irq #(.PIN_COUNT(N)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_now  (lvl_now),
    .lvl_prev (lvl_prev),
    .itype    (itype),
    .ipol     (ipol),
    .iboth    (iboth),
    .mask     (mask),
    .stat_rd  (stat_rd),
    .status   (status),
    .irq      (irq)
  );

  generate
    for (genvar p = 0; p < N; p++) begin : g_mux
      always_comb begin
        if (alt_sel[p]) begin
          pin_out[p] = alt_out[p];
          pin_oe[p]  = alt_oe[p];
        end else begin
          pin_out[p] = dout[p];
          pin_oe[p]  = oe[p] & ~dir[p];
        end
      end
    end
  endgenerate

  // R3
  input_never_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & ~alt_sel & dir) == '0));

  // R4
  alt_drives_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((((pin_out ^ alt_out) | (pin_oe ^ alt_oe)) & alt_sel) == '0));

  // R12
  write_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_enable) |=> ($stable(oe) && $stable(dout) && $stable(dir)));
endmodule

// File: tb/pinctl_gpio_bench.sv
`timescale 1ns/1ps
module pinctl_gpio_bench;
  localparam int unsigned N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_enable = 1'b0, bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [N-1:0] pin_in = '0, alt_out = '0, alt_oe = '0;
  logic [N-1:0] pin_out, pin_oe, alt_in;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pinctl_gpio #(.PIN_COUNT(N), .ALT_RST(32'h81)) u_pinctl_gpio (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_enable(bus_enable), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in), .irq(irq)
  );

  localparam logic [5:0] A_ALT = 6'h00, A_DIR = 6'h04, A_OE = 6'h08,
    A_DOUT = 6'h0C, A_DIN = 6'h10, A_MASK = 6'h14, A_UNMK = 6'h18,
    A_SETM = 6'h1C, A_STAT = 6'h20, A_TYPE = 6'h24, A_POL = 6'h28,
    A_BOTH = 6'h2C;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_enable = 1'b0; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_enable = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0;
  endtask

  // starts the setup phase at the current time (caller sits on a falling edge)
  task automatic rd_now(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_enable = 1'b0; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_enable = 1'b1;
    #0.5;
    d = bus_rdata;
    chk("R12 ready", {31'b0, bus_ready}, 32'h1);
    @(negedge clk);
    bus_sel = 1'b0; bus_enable = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic expect_reg(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic set_pins(input logic [N-1:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic flush();
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rd(A_STAT, d);
    rd(A_STAT, d);
  endtask

  task automatic t_reset();
    expect_reg("R1 alt", A_ALT, 32'h81);
    expect_reg("R1 dir", A_DIR, 32'hFF);
    expect_reg("R1 oe", A_OE, 32'h0);
    expect_reg("R1 dout", A_DOUT, 32'h0);
    expect_reg("R1 mask", A_MASK, 32'hFF);
    expect_reg("R1 stat", A_STAT, 32'h0);
    expect_reg("R1 type", A_TYPE, 32'h0);
    expect_reg("R1 pol", A_POL, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_bus();
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = A_DOUT; bus_wdata = 32'h11;
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0;
    expect_reg("R12 setup only", A_DOUT, 32'h0);
  endtask

  task automatic t_regs();
    wr(A_DOUT, 32'hFFFF_FFFF);
    expect_reg("R2 upper zero", A_DOUT, 32'hFF);
    wr(A_TYPE, 32'hFFFF_FF5A);
    expect_reg("R2 type", A_TYPE, 32'h5A);
    wr(A_TYPE, 32'h0);
    expect_reg("R2 unmapped 30", 6'h30, 32'h0);
    expect_reg("R2 unmapped 3C", 6'h3C, 32'h0);
  endtask

  task automatic t_dir();
    wr(A_ALT, 32'h0);
    wr(A_DIR, 32'h0F);
    wr(A_OE, 32'hFF);
    wr(A_DOUT, 32'hA5);
    #0.5;
    chk("R3 oe", {24'b0, pin_oe}, 32'hF0);
    chk("R3 out", {24'b0, pin_out}, 32'hA5);
    wr(A_OE, 32'h30);
    #0.5;
    chk("R3 oe partial", {24'b0, pin_oe}, 32'h30);
  endtask

  task automatic t_bypass();
    alt_out = 8'h3C; alt_oe = 8'h0F;
    wr(A_ALT, 32'h0F);
    #0.5;
    chk("R4 out", {24'b0, pin_out}, 32'hAC);
    chk("R4 oe", {24'b0, pin_oe}, 32'h3F);
    pin_in = 8'h96;
    #0.5;
    chk("R4 alt_in", {24'b0, alt_in}, 32'h96);
    wr(A_ALT, 32'h0);
  endtask

  task automatic t_din();
    logic [31:0] d;
    expect_reg("R5 dout readback", A_DOUT, 32'hA5);
    @(negedge clk);
    pin_in = 8'h3C;
    rd_now(A_DIN, d);
    chk("R5 din lag", d, 32'h96);
    expect_reg("R5 din", A_DIN, 32'h3C);
    set_pins(8'h00);
    flush();
  endtask

  task automatic t_mask();
    wr(A_UNMK, 32'h05);
    expect_reg("R6 unmask", A_MASK, 32'hFA);
    wr(A_UNMK, 32'h00);
    expect_reg("R6 zero write", A_MASK, 32'hFA);
    wr(A_SETM, 32'h01);
    expect_reg("R6 setmask", A_MASK, 32'hFB);
    expect_reg("R6 unmask reads zero", A_UNMK, 32'h0);
    wr(A_SETM, 32'hFF);
  endtask

  task automatic t_level();
    wr(A_UNMK, 32'h01);
    wr(A_POL, 32'h01);
    wr(A_TYPE, 32'h01);
    expect_reg("R7 idle", A_STAT, 32'h0);
    set_pins(8'h01);
    repeat (2) @(negedge clk);
    chk("R7 not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R11 irq level", {31'b0, irq}, 32'h1);
    expect_reg("R7 high", A_STAT, 32'h01);
    expect_reg("R7 persists", A_STAT, 32'h01);
    wr(A_TYPE, 32'h0);
    expect_reg("R7 drain", A_STAT, 32'h01);
    expect_reg("R10 cleared", A_STAT, 32'h0);
    chk("R11 irq low", {31'b0, irq}, 32'h0);
    set_pins(8'h00);
    wr(A_POL, 32'h00);
    wr(A_TYPE, 32'h02);
    expect_reg("R7 low level", A_STAT, 32'h02);
    chk("R11 masked", {31'b0, irq}, 32'h0);
    set_pins(8'h02);
    repeat (4) @(negedge clk);
    expect_reg("R7 drain low", A_STAT, 32'h02);
    expect_reg("R7 stopped", A_STAT, 32'h0);
    wr(A_TYPE, 32'h0);
    set_pins(8'h00);
    flush();
    wr(A_SETM, 32'h01);
  endtask

  task automatic t_edge();
    wr(A_POL, 32'h04);
    wr(A_UNMK, 32'h04);
    set_pins(8'h04);
    repeat (2) @(negedge clk);
    chk("R8 two edges", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 third edge", {31'b0, irq}, 32'h1);
    expect_reg("R8 rise", A_STAT, 32'h04);
    expect_reg("R8 once", A_STAT, 32'h0);
    chk("R11 cleared irq", {31'b0, irq}, 32'h0);
    set_pins(8'h00);
    repeat (4) @(negedge clk);
    expect_reg("R8 fall ignored", A_STAT, 32'h0);
    set_pins(8'h08);
    repeat (4) @(negedge clk);
    expect_reg("R8 rise ignored", A_STAT, 32'h0);
    set_pins(8'h00);
    repeat (4) @(negedge clk);
    chk("R11 masked edge", {31'b0, irq}, 32'h0);
    expect_reg("R8 fall", A_STAT, 32'h08);
  endtask

  task automatic t_any();
    wr(A_BOTH, 32'h10);
    set_pins(8'h10);
    repeat (4) @(negedge clk);
    expect_reg("R9 rise", A_STAT, 32'h10);
    set_pins(8'h00);
    repeat (4) @(negedge clk);
    expect_reg("R9 fall", A_STAT, 32'h10);
    wr(A_BOTH, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    @(negedge clk);
    pin_in = 8'h04;
    @(negedge clk);
    rd_now(A_STAT, d);
    chk("R10 read before event", d, 32'h0);
    expect_reg("R10 event kept", A_STAT, 32'h04);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bus();
    t_regs();
    t_dir();
    t_bypass();
    t_din();
    t_mask();
    t_level();
    t_edge();
    t_any();
    t_race();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule